// File: doc/BRIEF.md
# Memory Ordering Hazard Guard

This block watches the memory operations of an out-of-order core for ordering violations. It keeps two circular queues, one for executed loads and one for stores whose addresses are known. Each queue holds up to 32 entries, kept from oldest to youngest, and an entry stays until the core retires it or a flush discards it. Each queued load records its sequence number, its 8-byte block address and a predictor index taken from its PC. Each queued store records its sequence number and its full address.

When a store address arrives, the block compares it with every queued load. A match on a load that is younger than the store means that load read stale data. The block then reports a replay from the oldest such load and sets a one-bit flag in a 64-entry predictor. The issue logic looks up that predictor for every new load and holds back loads whose flag is set. When a load arrives, it is compared with the queued stores, and a match on an older store is reported as a dependence hit. Retired stores leave the store queue in order and appear on a drain output toward the data cache. A flush carrying a sequence number removes every younger entry from both queues in a single cycle.

Sequence numbers are 6 bits wide and wrap around. Age is decided by the sign of the 6-bit difference, so the operations in flight must span fewer than 32 sequence values. Each queue receives its own operations in increasing sequence order. An operation that arrives is compared only with entries that were queued before that cycle.

Top module: `memord_guard`

## Requirements
- R1: Each queue holds at most 32 entries. `ld_full` or `st_full` is high while its queue holds 32 entries. An arrival at a full queue is dropped and is never compared later.
- R2: A store arrival whose block matches one or more queued loads that are younger than the store drives `replay_valid` high in the next cycle. In that cycle `replay_seq` carries the sequence number of the oldest of those loads.
- R3: A block is the address with bits [2:0] removed. Two addresses in the same 8-byte block match even when their low bits differ. Loads that are older than the store, and loads in other blocks, never cause a replay.
- R4: On a replay, the predictor flag for the reported load is set on the same clock edge. The flag is indexed by PC bits [7:2]. `pred_wait` is a combinational lookup of `pred_pc` through the same bits. Every PC that shares those bits reads the flag, and other flags do not change.
- R5: A load arrival whose block matches a queued store that is older than the load drives `ld_fwd_hit` high in the next cycle. Stores younger than the load do not cause a hit.
- R6: `st_retire` removes the oldest store. In the next cycle `drain_valid` is high and `drain_addr` and `drain_seq` carry that store's address and sequence number. `st_retire` on an empty queue leaves `drain_valid` low.
- R7: `ld_retire` removes the oldest load, and a removed load can no longer cause a replay.
- R8: `flush_valid` removes every entry in both queues that is younger than `flush_seq` in that cycle and keeps the older entries. Arrivals in the same cycle are dropped and are not compared.
- R9: Age is compared modulo 64, so sequence 1 is younger than sequence 63.
- R10: Synchronous active-high reset empties both queues, clears all predictor flags and drives every registered output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_in_valid | input | 1 | An executed load arrives |
| ld_in_seq | input | 6 | Sequence number of the arriving load |
| ld_in_addr | input | 32 | Address of the arriving load |
| ld_in_pc | input | 32 | PC of the arriving load |
| st_in_valid | input | 1 | A store address arrives |
| st_in_seq | input | 6 | Sequence number of the arriving store |
| st_in_addr | input | 32 | Address of the arriving store |
| ld_retire | input | 1 | Remove the oldest load |
| st_retire | input | 1 | Remove the oldest store and send it to drain |
| flush_valid | input | 1 | Discard entries younger than flush_seq |
| flush_seq | input | 6 | Sequence number at the flush boundary |
| pred_pc | input | 32 | PC of a load about to issue |
| pred_wait | output | 1 | That load must wait instead of speculating |
| ld_full | output | 1 | Load queue holds 32 entries |
| st_full | output | 1 | Store queue holds 32 entries |
| ld_fwd_hit | output | 1 | The previous load matched an older queued store |
| replay_valid | output | 1 | An ordering violation was found |
| replay_seq | output | 6 | Sequence number of the load to replay from |
| drain_valid | output | 1 | A retired store leaves toward the cache |
| drain_addr | output | 32 | Address of the draining store |
| drain_seq | output | 6 | Sequence number of the draining store |

## Verification
The hardest case to reach is a violation on the far side of the sequence wrap. An older-looking store must land behind loads whose numbers have already rolled over, and the queue order must still choose the oldest match. The stimulus resets the block and then issues loads numbered 62 and 1 to one block, followed by a store numbered 63. The expected replay names load 1. A second hard case is the dropped arrival at a full queue. The bench fills the load queue with 32 distinct blocks, offers a 33rd load, and then sends an older store aimed at that 33rd load's block to show that no entry was created.

// File: rtl/memord_pkg.sv
package memord_pkg;

    localparam int SEQ_W      = 6;
    localparam int QDEPTH     = 32;
    localparam int ADDR_W     = 32;
    localparam int BLK_LSB    = 3;
    localparam int PC_LSB     = 2;
    localparam int PRED_IDX_W = 6;

    typedef logic [SEQ_W-1:0]          seq_t;
    typedef logic [ADDR_W-1:0]         addr_t;
    typedef logic [ADDR_W-BLK_LSB-1:0] blk_t;
    typedef logic [PRED_IDX_W-1:0]     pidx_t;

    typedef struct packed {
        seq_t  seq;
        blk_t  blk;
        pidx_t pidx;
    } ld_ent_t;

    typedef struct packed {
        seq_t  seq;
        addr_t addr;
    } st_ent_t;

    // a is younger than b when the wrapped difference is positive
    function automatic logic younger(seq_t a, seq_t b);
        seq_t d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    function automatic blk_t blk_of(addr_t a);
        return a[ADDR_W-1:BLK_LSB];
    endfunction

    function automatic pidx_t pidx_of(addr_t pc);
        return pc[PC_LSB +: PRED_IDX_W];
    endfunction

endpackage

// File: rtl/memord_ldq.sv
module memord_ldq
    import memord_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  ld_ent_t push_ent,
    input  logic    pop,
    input  logic    flush,
    input  seq_t    flush_seq,
    input  logic    probe,
    input  seq_t    probe_seq,
    input  blk_t    probe_blk,
    output logic    hit,
    output ld_ent_t hit_ent,
    output logic    full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    ld_ent_t            mem [DEPTH];
    logic [IDX_W-1:0]   head;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   kept;
    logic [CNT_W-1:0]   base;
    logic [CNT_W-1:0]   cnt_nx;
    logic [IDX_W-1:0]   slot;
    logic [IDX_W-1:0]   wr_slot;
    logic               pop_ok;
    logic               push_ok;

    // oldest younger matching load, scanned from the head
    always_comb begin
        hit     = 1'b0;
        hit_ent = '0;
        slot    = head;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head + IDX_W'(k);
            if (probe && !hit && (CNT_W'(k) < cnt) &&
                mem[slot].blk == probe_blk &&
                younger(mem[slot].seq, probe_seq)) begin
                hit     = 1'b1;
                hit_ent = mem[slot];
            end
        end
    end

    // number of live entries not younger than the flush boundary
    always_comb begin
        kept = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if ((CNT_W'(k) < cnt) &&
                !younger(mem[IDX_W'(head + IDX_W'(k))].seq, flush_seq))
                kept = kept + 1'b1;
        end
    end

    always_comb begin
        full    = (cnt == CNT_W'(DEPTH));
        base    = flush ? kept : cnt;
        pop_ok  = pop && (base != '0);
        push_ok = push && !flush && !full;
        cnt_nx  = base - CNT_W'(pop_ok) + CNT_W'(push_ok);
        wr_slot = head + cnt[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            head <= head + IDX_W'(pop_ok);
            cnt  <= cnt_nx;
            if (push_ok)
                mem[wr_slot] <= push_ent;
        end
    end

endmodule

// File: rtl/memord_stq.sv
module memord_stq
    import memord_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  st_ent_t push_ent,
    input  logic    pop,
    input  logic    flush,
    input  seq_t    flush_seq,
    input  logic    probe,
    input  seq_t    probe_seq,
    input  blk_t    probe_blk,
    output logic    hit,
    output logic    pop_ok,
    output st_ent_t head_ent,
    output logic    full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    st_ent_t            mem [DEPTH];
    logic [IDX_W-1:0]   head;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   kept;
    logic [CNT_W-1:0]   base;
    logic [CNT_W-1:0]   cnt_nx;
    logic [IDX_W-1:0]   slot;
    logic [IDX_W-1:0]   wr_slot;
    logic               push_ok;

    // any older store in the same block
    always_comb begin
        hit  = 1'b0;
        slot = head;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head + IDX_W'(k);
            if (probe && (CNT_W'(k) < cnt) &&
                blk_of(mem[slot].addr) == probe_blk &&
                younger(probe_seq, mem[slot].seq))
                hit = 1'b1;
        end
    end

    always_comb begin
        kept = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if ((CNT_W'(k) < cnt) &&
                !younger(mem[IDX_W'(head + IDX_W'(k))].seq, flush_seq))
                kept = kept + 1'b1;
        end
    end

    always_comb begin
        full     = (cnt == CNT_W'(DEPTH));
        base     = flush ? kept : cnt;
        pop_ok   = pop && (base != '0);
        push_ok  = push && !flush && !full;
        cnt_nx   = base - CNT_W'(pop_ok) + CNT_W'(push_ok);
        wr_slot  = head + cnt[IDX_W-1:0];
        head_ent = mem[head];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            head <= head + IDX_W'(pop_ok);
            cnt  <= cnt_nx;
            if (push_ok)
                mem[wr_slot] <= push_ent;
        end
    end

endmodule

// File: rtl/memord_pred.sv
module memord_pred
    import memord_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  train,
    input  pidx_t train_idx,
    input  pidx_t look_idx,
    output logic  hold
);
    localparam int ENTRIES = 2 ** PRED_IDX_W;

    logic [ENTRIES-1:0] flags;

    assign hold = flags[look_idx];

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (train)
            flags[train_idx] <= 1'b1;
    end

endmodule

// File: rtl/memord_guard.sv
module memord_guard
    import memord_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_in_valid,
    input  logic [SEQ_W-1:0]  ld_in_seq,
    input  logic [ADDR_W-1:0] ld_in_addr,
    input  logic [ADDR_W-1:0] ld_in_pc,
    input  logic              st_in_valid,
    input  logic [SEQ_W-1:0]  st_in_seq,
    input  logic [ADDR_W-1:0] st_in_addr,
    input  logic              ld_retire,
    input  logic              st_retire,
    input  logic              flush_valid,
    input  logic [SEQ_W-1:0]  flush_seq,
    input  logic [ADDR_W-1:0] pred_pc,
    output logic              pred_wait,
    output logic              ld_full,
    output logic              st_full,
    output logic              ld_fwd_hit,
    output logic              replay_valid,
    output logic [SEQ_W-1:0]  replay_seq,
    output logic              drain_valid,
    output logic [ADDR_W-1:0] drain_addr,
    output logic [SEQ_W-1:0]  drain_seq
);
    ld_ent_t ld_new;
    st_ent_t st_new;
    ld_ent_t viol_ent;
    st_ent_t st_head;
    logic    viol;
    logic    dep_hit;
    logic    st_pop_ok;
    logic    st_probe;
    logic    ld_probe;

    always_comb begin
        ld_new.seq  = ld_in_seq;
        ld_new.blk  = blk_of(ld_in_addr);
        ld_new.pidx = pidx_of(ld_in_pc);
        st_new.seq  = st_in_seq;
        st_new.addr = st_in_addr;
        st_probe    = st_in_valid && !flush_valid;
        ld_probe    = ld_in_valid && !flush_valid;
    end

    memord_ldq #(.DEPTH(DEPTH)) u_ldq (
        .clk       (clk),
        .rst       (rst),
        .push      (ld_in_valid),
        .push_ent  (ld_new),
        .pop       (ld_retire),
        .flush     (flush_valid),
        .flush_seq (flush_seq),
        .probe     (st_probe),
        .probe_seq (st_in_seq),
        .probe_blk (blk_of(st_in_addr)),
        .hit       (viol),
        .hit_ent   (viol_ent),
        .full      (ld_full)
    );

    memord_stq #(.DEPTH(DEPTH)) u_stq (
        .clk       (clk),
        .rst       (rst),
        .push      (st_in_valid),
        .push_ent  (st_new),
        .pop       (st_retire),
        .flush     (flush_valid),
        .flush_seq (flush_seq),
        .probe     (ld_probe),
        .probe_seq (ld_in_seq),
        .probe_blk (blk_of(ld_in_addr)),
        .hit       (dep_hit),
        .pop_ok    (st_pop_ok),
        .head_ent  (st_head),
        .full      (st_full)
    );

    memord_pred u_pred (
        .clk       (clk),
        .rst       (rst),
        .train     (viol),
        .train_idx (viol_ent.pidx),
        .look_idx  (pidx_of(pred_pc)),
        .hold      (pred_wait)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            replay_valid <= 1'b0;
            replay_seq   <= '0;
            ld_fwd_hit   <= 1'b0;
            drain_valid  <= 1'b0;
            drain_addr   <= '0;
            drain_seq    <= '0;
        end else begin
            replay_valid <= viol;
            replay_seq   <= viol ? viol_ent.seq : '0;
            ld_fwd_hit   <= dep_hit;
            drain_valid  <= st_pop_ok;
            drain_addr   <= st_pop_ok ? st_head.addr : '0;
            drain_seq    <= st_pop_ok ? st_head.seq : '0;
        end
    end

endmodule

// File: rtl/memord_guard_chk.sv
module memord_guard_chk (
    input logic clk,
    input logic rst,
    input logic ld_in_valid,
    input logic st_in_valid,
    input logic ld_retire,
    input logic st_retire,
    input logic flush_valid,
    input logic ld_full,
    input logic ld_fwd_hit,
    input logic replay_valid,
    input logic drain_valid
);
    p_full_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (ld_full && !ld_retire && !flush_valid) |=> ld_full);

    p_replay_cause_r2: assert property (@(posedge clk) disable iff (rst)
        replay_valid |-> $past(st_in_valid && !flush_valid));

    p_fwd_cause_r5: assert property (@(posedge clk) disable iff (rst)
        ld_fwd_hit |-> $past(ld_in_valid && !flush_valid));

    p_drain_cause_r6: assert property (@(posedge clk) disable iff (rst)
        drain_valid |-> $past(st_retire));

    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> (!replay_valid && !ld_fwd_hit));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!replay_valid && !drain_valid && !ld_fwd_hit && !ld_full));

endmodule

bind memord_guard memord_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_in_valid  (ld_in_valid),
    .st_in_valid  (st_in_valid),
    .ld_retire    (ld_retire),
    .st_retire    (st_retire),
    .flush_valid  (flush_valid),
    .ld_full      (ld_full),
    .ld_fwd_hit   (ld_fwd_hit),
    .replay_valid (replay_valid),
    .drain_valid  (drain_valid)
);

// File: tb/memord_guard_bench.sv
`timescale 1ns/1ps
module memord_guard_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_in_valid = 0, st_in_valid = 0, ld_retire = 0, st_retire = 0, flush_valid = 0;
    logic [5:0]  ld_in_seq = 0, st_in_seq = 0, flush_seq = 0;
    logic [31:0] ld_in_addr = 0, ld_in_pc = 0, st_in_addr = 0, pred_pc = 0;
    logic        pred_wait, ld_full, st_full, ld_fwd_hit, replay_valid, drain_valid;
    logic [5:0]  replay_seq, drain_seq;
    logic [31:0] drain_addr;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    memord_guard u_memord_guard (
        .clk(clk), .rst(rst),
        .ld_in_valid(ld_in_valid), .ld_in_seq(ld_in_seq), .ld_in_addr(ld_in_addr), .ld_in_pc(ld_in_pc),
        .st_in_valid(st_in_valid), .st_in_seq(st_in_seq), .st_in_addr(st_in_addr),
        .ld_retire(ld_retire), .st_retire(st_retire),
        .flush_valid(flush_valid), .flush_seq(flush_seq),
        .pred_pc(pred_pc), .pred_wait(pred_wait),
        .ld_full(ld_full), .st_full(st_full), .ld_fwd_hit(ld_fwd_hit),
        .replay_valid(replay_valid), .replay_seq(replay_seq),
        .drain_valid(drain_valid), .drain_addr(drain_addr), .drain_seq(drain_seq)
    );

    typedef struct packed {
        logic [1:0]  op;     // 1 load, 2 store
        logic [5:0]  seq;
        logic [31:0] addr;
        logic [31:0] pc;
        logic [31:0] ppc;
        logic        e_rpl;
        logic [5:0]  e_rseq;
        logic        e_fwd;
        logic        e_wait;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{2'd1, 6'd1, 32'h100, 32'h40, 32'h40,  1'b0, 6'd0, 1'b0, 1'b0},
        '{2'd1, 6'd3, 32'h208, 32'h44, 32'h44,  1'b0, 6'd0, 1'b0, 1'b0},
        '{2'd2, 6'd2, 32'h20C, 32'h0,  32'h44,  1'b1, 6'd3, 1'b0, 1'b1},
        '{2'd2, 6'd4, 32'h100, 32'h0,  32'h144, 1'b0, 6'd0, 1'b0, 1'b1},
        '{2'd1, 6'd5, 32'h104, 32'h48, 32'h48,  1'b0, 6'd0, 1'b1, 1'b0},
        '{2'd1, 6'd6, 32'h300, 32'h4C, 32'h40,  1'b0, 6'd0, 1'b0, 1'b0},
        '{2'd2, 6'd7, 32'h300, 32'h0,  32'h4C,  1'b0, 6'd0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus, sample 1 ns after the edge
    task automatic cyc(input bit l, input logic [5:0] ls, input logic [31:0] la, input logic [31:0] lp,
                       input bit s, input logic [5:0] ss, input logic [31:0] sa,
                       input bit lr, input bit sr, input bit f, input logic [5:0] fs);
        @(negedge clk);
        ld_in_valid = l;  ld_in_seq = ls; ld_in_addr = la; ld_in_pc = lp;
        st_in_valid = s;  st_in_seq = ss; st_in_addr = sa;
        ld_retire = lr;   st_retire = sr;
        flush_valid = f;  flush_seq = fs;
        @(posedge clk);
        #1;
        ld_in_valid = 0; st_in_valid = 0; ld_retire = 0; st_retire = 0; flush_valid = 0;
    endtask

    task automatic ld(input logic [5:0] q, input logic [31:0] a, input logic [31:0] p);
        cyc(1, q, a, p, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic st(input logic [5:0] q, input logic [31:0] a);
        cyc(0, 0, 0, 0, 1, q, a, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        do_reset();

        // vector table: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            pred_pc = VEC[i].ppc;
            if (VEC[i].op == 2'd1) ld(VEC[i].seq, VEC[i].addr, VEC[i].pc);
            else                   st(VEC[i].seq, VEC[i].addr);
            chk(replay_valid == VEC[i].e_rpl, "R2/R3 replay_valid", 32'(replay_valid), 32'(VEC[i].e_rpl));
            if (VEC[i].e_rpl)
                chk(replay_seq == VEC[i].e_rseq, "R2 replay_seq", 32'(replay_seq), 32'(VEC[i].e_rseq));
            chk(ld_fwd_hit == VEC[i].e_fwd, "R5 ld_fwd_hit", 32'(ld_fwd_hit), 32'(VEC[i].e_fwd));
            chk(pred_wait == VEC[i].e_wait, "R4 pred_wait", 32'(pred_wait), 32'(VEC[i].e_wait));
        end

        // R10: reset clears queues, flags and outputs
        do_reset();
        pred_pc = 32'h44;
        #1;
        chk(pred_wait == 0, "R10 predictor cleared", 32'(pred_wait), 0);
        chk(!replay_valid && !ld_fwd_hit && !drain_valid, "R10 outputs low",
            {29'd0, replay_valid, ld_fwd_hit, drain_valid}, 0);
        chk(!ld_full && !st_full, "R10 queues empty", {30'd0, ld_full, st_full}, 0);
        st(6'd5, 32'h100);
        chk(!replay_valid, "R10 no stale load entries", 32'(replay_valid), 0);

        // R2 oldest of several, R4 only that load trained
        do_reset();
        ld(6'd10, 32'h800, 32'h60);
        ld(6'd12, 32'h800, 32'h64);
        st(6'd9, 32'h800);
        chk(replay_valid == 1, "R2 multi replay_valid", 32'(replay_valid), 1);
        chk(replay_seq == 6'd10, "R2 oldest replay_seq", 32'(replay_seq), 10);
        pred_pc = 32'h60; #1;
        chk(pred_wait == 1, "R4 trained flag", 32'(pred_wait), 1);
        pred_pc = 32'h64; #1;
        chk(pred_wait == 0, "R4 untouched flag", 32'(pred_wait), 0);

        // R7 load retire removes oldest loads
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        st(6'd11, 32'h800);
        chk(replay_valid == 0, "R7 retired load no replay", 32'(replay_valid), 0);

        // R6 drain in order, then empty
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk(drain_valid == 1 && drain_addr == 32'h800 && drain_seq == 6'd9, "R6 first drain",
            {drain_seq, drain_addr[25:0]}, {6'd9, 26'h800});
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk(drain_valid == 1 && drain_seq == 6'd11, "R6 second drain", 32'(drain_seq), 11);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk(drain_valid == 0, "R6 empty drain", 32'(drain_valid), 0);

        // R1 full load queue, dropped arrival
        do_reset();
        for (int i = 0; i < 32; i++) begin
            ld(6'(i), 32'h1000 + 32'(i) * 8, 32'h0);
            if (i == 30) chk(ld_full == 0, "R1 not full at 31", 32'(ld_full), 0);
        end
        chk(ld_full == 1, "R1 full at 32", 32'(ld_full), 1);
        ld(6'd32, 32'h2000, 32'h0);
        chk(ld_full == 1, "R1 still full", 32'(ld_full), 1);
        st(6'd31, 32'h2000);
        chk(replay_valid == 0, "R1 dropped load not compared", 32'(replay_valid), 0);
        do_reset();
        for (int i = 0; i < 32; i++) st(6'(i), 32'h3000 + 32'(i) * 8);
        chk(st_full == 1, "R1 store queue full", 32'(st_full), 1);

        // R8 flush trims younger entries, drops same-cycle arrival
        do_reset();
        ld(6'd1, 32'hA00, 32'h70);
        ld(6'd5, 32'hA00, 32'h74);
        st(6'd3, 32'hB00);
        st(6'd6, 32'hB00);
        cyc(1, 6'd4, 32'hA00, 32'h78, 0, 0, 0, 0, 0, 1, 6'd3);
        chk(replay_valid == 0 && ld_fwd_hit == 0, "R8 quiet after flush",
            {30'd0, replay_valid, ld_fwd_hit}, 0);
        st(6'd4, 32'hA00);
        chk(replay_valid == 0, "R8 younger loads gone", 32'(replay_valid), 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk(drain_valid == 1 && drain_seq == 6'd3, "R8 older store kept", 32'(drain_seq), 3);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk(drain_valid == 1 && drain_seq == 6'd4, "R8 next store", 32'(drain_seq), 4);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk(drain_valid == 0, "R8 younger store gone", 32'(drain_valid), 0);

        // R9 wraparound age
        do_reset();
        ld(6'd62, 32'hC00, 32'h7C);
        ld(6'd1, 32'hC00, 32'h80);
        st(6'd63, 32'hC00);
        chk(replay_valid == 1 && replay_seq == 6'd1, "R9 wrapped replay", 32'(replay_seq), 1);
        ld(6'd2, 32'hC04, 32'h84);
        chk(ld_fwd_hit == 1, "R9 wrapped older store", 32'(ld_fwd_hit), 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule